// File: doc/BRIEF.md
# Near-Base Residual Integer Multiplier

This block multiplies two unsigned W-bit integers without adding up a full set of partial products. Each operand is split into a power-of-two base and a small signed residual, so that X = 2^k1 ± Z1 and Y = 2^k2 ± Z2. The two operands may use different bases. Expanding the product gives 2^k2·(X ± Z2·2^(k1−k2)) ± Z1·Z2. The large term therefore needs only shifts and one add/subtract. A narrow array multiply forms the residual product Z1·Z2.

The base for each operand is chosen as follows. Let e be the position of the operand's highest set bit. The base is 2^(e+1) when the operand is greater than 3·2^(e−1), and 2^e otherwise. The residual is the distance from the operand to its base. The operand with the larger exponent is used as the first term, so the alignment shift is never negative.

A caller pulses `start` with both operands while the block is idle. Some cycles later `done` pulses for one clock and `product` holds the exact result.

The state machine has five states:
- IDLE waits for `start`.
- SPLIT registers the base, residual and sign of each operand and orders the two operands. It goes to MERGE when an operand is zero, and to ALIGN otherwise.
- ALIGN forms X ± Z2·2^(k1−k2).
- SCALE shifts that sum by 2^k2 and registers Z1·Z2.
- MERGE adds or subtracts the residual product, raises `done` and returns to IDLE.

Top module: `nb_mul`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy` is 0, `done` is 0 and `product` is 0.
- R2: For nonzero operands, the `product` presented with `done` equals opa·opb as an unsigned 2W-bit value.
- R3: The result is exact when the second operand selects a larger base exponent than the first (the operands are swapped internally), and when the exponents are equal.
- R4: The result is exact for every combination of residual signs: both operands above their bases, both below, and one of each.
- R5: An operand equal to 3·2^(e−1) takes the lower base 2^e, and an operand one above it takes 2^(e+1). Both cases give an exact product, and an operand of 1 takes base 2^0.
- R6: When either operand is 0, `product` is 0 and `done` follows on the second rising edge after the start edge.
- R7: For nonzero operands, `done` follows on the fourth rising edge after the edge that accepted `start`.
- R8: `done` is high for exactly one cycle, and `product` keeps its value until the next result is presented.
- R9: `busy` is high from the accepting edge until `done`. A `start` seen while `busy` is high is ignored and changes neither the result under way nor the number of `done` pulses.
- R10: Operands at the top of the range (2^W−1, which takes base 2^W) give an exact product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication; sampled only while idle |
| opa | input | W | First unsigned operand, sampled with start |
| opb | input | W | Second unsigned operand, sampled with start |
| busy | output | 1 | High while an operation is in flight |
| done | output | 1 | One-cycle pulse when product is valid |
| product | output | 2W | Unsigned product, held between results |

## Verification
The checker assumes that operands are sampled only on the edge where `start` is high and `busy` is low. It compares `done` and the latency against operands it captures at that edge, so it relies on the caller treating `start` as a request that is taken only when idle. The bench always changes `opa`, `opb` and `start` at falling edges and never relies on any other sampling. When it does drive `start` during a busy period, the operands it drives are deliberately different, so that an accepted stray request would show up as a wrong product or an extra `done`.

// File: rtl/nb_pkg.sv
package nb_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_SPLIT,
        S_ALIGN,
        S_SCALE,
        S_MERGE
    } nb_state_e;
endpackage

// File: rtl/nb_split.sv
// Picks the power-of-two base nearest an operand and returns the residual.
module nb_split #(
    parameter int W  = 8,
    parameter int KW = 4
) (
    input  logic [W-1:0]  val,
    output logic [KW-1:0] kexp,
    output logic [W-1:0]  resid,
    output logic          below
);
    int         msb;
    logic [W:0] ext, lo, hi, thr, diff;

    always_comb begin
        msb = 0;
        for (int i = 0; i < W; i++) begin
            if (val[i]) msb = i;
        end
        ext = {1'b0, val};
        lo  = {{W{1'b0}}, 1'b1} << msb;
        hi  = lo << 1;
        thr = lo + (lo >> 1);          // midpoint 3*2^(msb-1)
        if (ext > thr) begin
            kexp  = KW'(msb + 1);
            diff  = hi - ext;
            below = 1'b1;
        end else begin
            kexp  = KW'(msb);
            diff  = ext - lo;
            below = 1'b0;
        end
        resid = diff[W-1:0];
    end
endmodule

// File: rtl/nb_arraymul.sv
// Plain unsigned array multiply for the residual product.
module nb_arraymul #(
    parameter int W = 8
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);
    logic [2*W-1:0] acc [W+1];

    assign acc[0] = '0;
    for (genvar i = 0; i < W; i++) begin : g_row
        assign acc[i+1] = acc[i] + (b[i] ? ({{W{1'b0}}, a} << i) : '0);
    end
    assign p = acc[W];
endmodule

// File: rtl/nb_mul.sv
module nb_mul
    import nb_pkg::*;
#(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    output logic           busy,
    output logic           done,
    output logic [2*W-1:0] product
);
    localparam int KW = $clog2(W + 1);
    localparam int AW = 2 * W + 4;

    nb_state_e state, nxt;

    logic [W-1:0]  xa, yb;
    logic [KW-1:0] ka, kb;
    logic [W-1:0]  za, zb;
    logic          sa, sb;

    logic [KW-1:0] k_hi, k_lo;
    logic [W-1:0]  z_hi, z_lo, x_hi;
    logic          s_hi, s_lo, zero_q;

    logic signed [AW-1:0] t1, t2, mix;
    logic [2*W-1:0]       rp_c, rp_q;

    nb_split #(.W(W), .KW(KW)) u_split_a (.val(xa), .kexp(ka), .resid(za), .below(sa));
    nb_split #(.W(W), .KW(KW)) u_split_b (.val(yb), .kexp(kb), .resid(zb), .below(sb));
    nb_arraymul #(.W(W)) u_resmul (.a(z_hi), .b(z_lo), .p(rp_c));

    assign busy = (state != S_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (start) nxt = S_SPLIT;
            S_SPLIT: nxt = (xa == '0 || yb == '0) ? S_MERGE : S_ALIGN;
            S_ALIGN: nxt = S_SCALE;
            S_SCALE: nxt = S_MERGE;
            S_MERGE: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // final combine: add residual product when signs agree
    always_comb begin
        if (s_hi == s_lo) mix = t2 + $signed({{(AW-2*W){1'b0}}, rp_q});
        else              mix = t2 - $signed({{(AW-2*W){1'b0}}, rp_q});
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xa <= '0; yb <= '0;
            k_hi <= '0; k_lo <= '0; z_hi <= '0; z_lo <= '0; x_hi <= '0;
            s_hi <= 1'b0; s_lo <= 1'b0; zero_q <= 1'b0;
            t1 <= '0; t2 <= '0; rp_q <= '0;
            done <= 1'b0; product <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        xa <= opa;
                        yb <= opb;
                    end
                end
                S_SPLIT: begin
                    zero_q <= (xa == '0 || yb == '0);
                    if (ka >= kb) begin
                        k_hi <= ka; z_hi <= za; s_hi <= sa; x_hi <= xa;
                        k_lo <= kb; z_lo <= zb; s_lo <= sb;
                    end else begin
                        k_hi <= kb; z_hi <= zb; s_hi <= sb; x_hi <= yb;
                        k_lo <= ka; z_lo <= za; s_lo <= sa;
                    end
                end
                S_ALIGN: begin
                    if (s_lo)
                        t1 <= $signed({{(AW-W){1'b0}}, x_hi})
                            - ($signed({{(AW-W){1'b0}}, z_lo}) <<< (k_hi - k_lo));
                    else
                        t1 <= $signed({{(AW-W){1'b0}}, x_hi})
                            + ($signed({{(AW-W){1'b0}}, z_lo}) <<< (k_hi - k_lo));
                end
                S_SCALE: begin
                    t2   <= t1 <<< k_lo;
                    rp_q <= rp_c;
                end
                S_MERGE: begin
                    done    <= 1'b1;
                    product <= zero_q ? '0 : mix[2*W-1:0];
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/nb_mul_chk.sv
module nb_mul_chk #(
    parameter int W = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [W-1:0]   opa,
    input logic [W-1:0]   opb,
    input logic           busy,
    input logic           done,
    input logic [2*W-1:0] product
);
    logic [W-1:0] ca, cb;
    logic         cz;
    logic [3:0]   cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ca <= '0; cb <= '0; cz <= 1'b0; cyc <= '0;
        end else if (start && !busy) begin
            ca <= opa; cb <= opb; cz <= (opa == '0 || opb == '0); cyc <= '0;
        end else if (busy && cyc != 4'hF) begin
            cyc <= cyc + 4'd1;
        end
    end

    p_exact_product_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> product == ({{W{1'b0}}, ca} * {{W{1'b0}}, cb}));
    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cyc == (cz ? 4'd2 : 4'd4));           // R6 also
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_product_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(product));
    p_busy_on_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    p_idle_at_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

bind nb_mul nb_mul_chk #(.W(W)) u_chk (.*);

// File: tb/tb_nb_mul.sv
module tb_nb_mul;
    localparam int W = 8;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           start;
    logic [W-1:0]   opa, opb;
    logic           busy, done;
    logic [2*W-1:0] product;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    nb_mul #(.W(W)) dut (.*);

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles, expected under 100000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // {opa, opb, tag}: tag 2=R2 3=R3 4=R4 5=R5 10=R10
    localparam logic [23:0] VEC [14] = '{
        {8'd13,  8'd11,  8'd2},
        {8'd100, 8'd77,  8'd2},
        {8'd5,   8'd7,   8'd3},   // k1 < k2, swap
        {8'd3,   8'd200, 8'd3},
        {8'd40,  8'd36,  8'd3},   // equal exponents
        {8'd9,   8'd17,  8'd4},   // both above
        {8'd15,  8'd30,  8'd4},   // both below
        {8'd60,  8'd33,  8'd4},   // mixed
        {8'd12,  8'd6,   8'd5},   // at midpoint: lower base
        {8'd13,  8'd7,   8'd5},   // one above midpoint
        {8'd1,   8'd1,   8'd5},
        {8'd1,   8'd129, 8'd5},
        {8'd255, 8'd255, 8'd10},
        {8'd255, 8'd128, 8'd10}
    };

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // launches one operation; returns negedges until done and the product
    task automatic run(input logic [W-1:0] a, input logic [W-1:0] b,
                       output int n, output logic [2*W-1:0] p);
        @(negedge clk);
        opa = a; opb = b; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
        end
        p = product;
    endtask

    initial begin
        int n;
        logic [2*W-1:0] p;
        logic [2*W-1:0] held;
        int pulses;

        rst_n = 1'b0; start = 1'b0; opa = '0; opb = '0;
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && product == '0, "R1 reset",
              {busy, done, product}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0 && product == '0, "R1 after reset",
              {busy, done, product}, 0);

        foreach (VEC[i]) begin
            logic [W-1:0] a, b;
            a = VEC[i][23:16];
            b = VEC[i][15:8];
            run(a, b, n, p);
            check(p == a * b, $sformatf("R%0d product %0dx%0d", VEC[i][7:0], a, b),
                  p, a * b);
            check(n == 5, "R7 latency", n, 5);   // R2 operand path
        end

        // R6: zero operands
        run(8'd0, 8'd77, n, p);
        check(p == 0, "R6 zero opa", p, 0);
        check(n == 3, "R6 zero latency", n, 3);
        run(8'd200, 8'd0, n, p);
        check(p == 0, "R6 zero opb", p, 0);

        // R8: one-cycle done, held product
        run(8'd21, 8'd19, n, p);
        held = product;
        @(negedge clk);
        check(done == 1'b0, "R8 done pulse width", done, 0);
        repeat (4) @(negedge clk);
        check(product == held && held == 16'd399, "R8 product held", product, 399);

        // R9: start during busy ignored
        @(negedge clk);
        opa = 8'd3; opb = 8'd5; start = 1'b1;
        @(negedge clk);
        check(busy == 1'b1, "R9 busy after accept", busy, 1);
        opa = 8'd200; opb = 8'd200;            // start still high while busy
        @(negedge clk);
        start = 1'b0;
        pulses = 0;
        for (int c = 0; c < 12; c++) begin
            if (done) begin
                pulses++;
                held = product;
            end
            @(negedge clk);
        end
        check(pulses == 1, "R9 single done", pulses, 1);
        check(held == 16'd15, "R9 stray start ignored", held, 15);
        check(busy == 1'b0, "R9 idle after done", busy, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule